// File: doc/BRIEF.md
# Cache Control Register with Valid-Bit Invalidation

This block holds the control word for a small data cache and a small instruction cache, together with the valid bits of both caches. Software writes the control word through a register-write port and reads it back through a read port. The stored bits drive the policy outputs that the cache datapaths use: enable, freeze and burst enable on each side, plus write allocate on the data side.

Four command bits in the word start invalidation. On each side there is one command that clears the whole valid array and one that clears a single long word. The single long word is chosen by a separate cache address register. Each command acts on the clock edge of the write that carries it, and it always reads back as zero.

The cache datapaths mark long words valid through a fill port and query them through a combinational lookup port. Each side has one valid bit per long word: 16 lines of 4 long words.

Top module: `cache_ctl_reg`

## Requirements
- R1: The readable control bits are: 13 write allocate, 12 data burst, 9 data freeze, 8 data enable, 4 instruction burst, 1 instruction freeze, 0 instruction enable. A write with `ctl_wr_en` stores them, and `ctl_rdata` returns them from the next cycle on.
- R2: `ctl_rdata` bits 31..14 and 7..5 always read as zero. The command bits 11, 10, 3 and 2 also always read as zero.
- R3: While `rst_n` is low, every control bit is cleared and every valid bit on both sides is cleared.
- R4: `d_enable`, `d_freeze`, `d_burst`, `i_enable`, `i_freeze` and `i_burst` each equal their stored control bit.
- R5: `d_write_alloc` is high only when bit 13 is set, the data cache is enabled and the data cache is not frozen. In every other case it is low, which selects no-write-allocate.
- R6: A control write with bit 11 set clears every data valid bit. A data lookup in the next cycle returns zero for every position.
- R7: A control write with bit 10 set clears only the data valid bit at the position held in the cache address register. This happens whatever the enable and freeze bits are. The address register is loaded by `caddr_wr_en`: bits 7..4 of `caddr_wdata` are the line index and bits 3..2 are the long-word select. The lookup and fill positions are {index, select}.
- R8: A control write with bit 3 set clears every instruction valid bit. A control write with bit 2 set clears only the instruction valid bit at the address-register position.
- R9: A fill sets the addressed valid bit, and the lookup shows it from the next cycle. If a clear covers the same position in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| caddr_wr_en | input | 1 | Cache address register write strobe |
| caddr_wdata | input | 32 | Cache address register write data |
| d_enable | output | 1 | Data cache enable |
| d_freeze | output | 1 | Data cache freeze |
| d_burst | output | 1 | Data burst fill enable |
| d_write_alloc | output | 1 | Effective write-allocate policy |
| i_enable | output | 1 | Instruction cache enable |
| i_freeze | output | 1 | Instruction cache freeze |
| i_burst | output | 1 | Instruction burst fill enable |
| d_fill_en | input | 1 | Data valid set strobe |
| d_fill_pos | input | 6 | Data fill position {index, select} |
| d_look_pos | input | 6 | Data lookup position |
| d_look_valid | output | 1 | Data valid bit at lookup position |
| i_fill_en | input | 1 | Instruction valid set strobe |
| i_fill_pos | input | 6 | Instruction fill position |
| i_look_pos | input | 6 | Instruction lookup position |
| i_look_valid | output | 1 | Instruction valid bit at lookup position |

## Verification
The bench writes the command bits and then reads the word back. A design that latched the commands would return non-zero in bits 11, 10, 3 or 2. Write allocate is tested with the data cache enabled, with it disabled, and with it frozen, to catch a bit that is passed straight through. Single-entry clears are issued on positions next to filled ones and with the cache disabled and frozen. A decoder that is off by one, or gated by enable, would either leave the target valid or wipe its neighbour. A fill that collides with a clear in the same cycle shows whether the clear really wins.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
    localparam int CTL_W   = 32;
    // control word bit positions
    localparam int B_IEN   = 0;
    localparam int B_IFRZ  = 1;
    localparam int B_ICLE  = 2;
    localparam int B_ICLA  = 3;
    localparam int B_IBST  = 4;
    localparam int B_DEN   = 8;
    localparam int B_DFRZ  = 9;
    localparam int B_DCLE  = 10;
    localparam int B_DCLA  = 11;
    localparam int B_DBST  = 12;
    localparam int B_WALC  = 13;

    typedef struct packed {
        logic walloc;
        logic d_burst;
        logic d_freeze;
        logic d_enable;
        logic i_burst;
        logic i_freeze;
        logic i_enable;
    } ctl_fields_t;

    typedef struct packed {
        logic d_all;
        logic d_one;
        logic i_all;
        logic i_one;
    } clr_cmd_t;
endpackage

// File: rtl/ctl_word_reg.sv
module ctl_word_reg
    import cache_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output ctl_fields_t      fields,
    output clr_cmd_t         cmd,
    output logic [CTL_W-1:0] rdata
);
    ctl_fields_t fields_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q.walloc   <= wdata[B_WALC];
            fields_q.d_burst  <= wdata[B_DBST];
            fields_q.d_freeze <= wdata[B_DFRZ];
            fields_q.d_enable <= wdata[B_DEN];
            fields_q.i_burst  <= wdata[B_IBST];
            fields_q.i_freeze <= wdata[B_IFRZ];
            fields_q.i_enable <= wdata[B_IEN];
        end
    end

    always_comb begin
        cmd.d_all = wr_en && wdata[B_DCLA];
        cmd.d_one = wr_en && wdata[B_DCLE];
        cmd.i_all = wr_en && wdata[B_ICLA];
        cmd.i_one = wr_en && wdata[B_ICLE];
    end

    always_comb begin
        rdata          = '0;
        rdata[B_WALC]  = fields_q.walloc;
        rdata[B_DBST]  = fields_q.d_burst;
        rdata[B_DFRZ]  = fields_q.d_freeze;
        rdata[B_DEN]   = fields_q.d_enable;
        rdata[B_IBST]  = fields_q.i_burst;
        rdata[B_IFRZ]  = fields_q.i_freeze;
        rdata[B_IEN]   = fields_q.i_enable;
    end

    assign fields = fields_q;
endmodule

// File: rtl/cache_addr_reg.sv
module cache_addr_reg #(
    parameter int IDX_W = 4,
    parameter int SEL_W = 2,
    localparam int POS_W = IDX_W + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    output logic [POS_W-1:0] pos
);
    // select sits just above the byte offset, index above the select
    localparam int LO = 2;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (wr_en)
            pos <= wdata[LO+POS_W-1:LO];
    end
endmodule

// File: rtl/cache_valid_array.sv
module cache_valid_array #(
    parameter int POS_W = 6,
    localparam int ENTRIES = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             clr_one,
    input  logic [POS_W-1:0] clr_pos,
    input  logic             fill_en,
    input  logic [POS_W-1:0] fill_pos,
    input  logic [POS_W-1:0] look_pos,
    output logic             look_valid
);
    logic [ENTRIES-1:0] vbits_q, vbits_d;

    always_comb begin
        vbits_d = vbits_q;
        if (fill_en) vbits_d[fill_pos] = 1'b1;
        if (clr_one) vbits_d[clr_pos]  = 1'b0;
        if (clr_all) vbits_d           = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vbits_q <= '0;
        else        vbits_q <= vbits_d;
    end

    assign look_valid = vbits_q[look_pos];
endmodule

// File: rtl/cache_ctl_reg.sv
module cache_ctl_reg
    import cache_ctl_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int SEL_W = 2,
    localparam int POS_W = IDX_W + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [31:0]      ctl_wdata,
    output logic [31:0]      ctl_rdata,
    input  logic             caddr_wr_en,
    input  logic [31:0]      caddr_wdata,
    output logic             d_enable,
    output logic             d_freeze,
    output logic             d_burst,
    output logic             d_write_alloc,
    output logic             i_enable,
    output logic             i_freeze,
    output logic             i_burst,
    input  logic             d_fill_en,
    input  logic [POS_W-1:0] d_fill_pos,
    input  logic [POS_W-1:0] d_look_pos,
    output logic             d_look_valid,
    input  logic             i_fill_en,
    input  logic [POS_W-1:0] i_fill_pos,
    input  logic [POS_W-1:0] i_look_pos,
    output logic             i_look_valid
);
    ctl_fields_t      fields;
    clr_cmd_t         cmd;
    logic [POS_W-1:0] entry_pos;

    ctl_word_reg u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl_wr_en),
        .wdata (ctl_wdata),
        .fields(fields),
        .cmd   (cmd),
        .rdata (ctl_rdata)
    );

    cache_addr_reg #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (caddr_wr_en),
        .wdata (caddr_wdata),
        .pos   (entry_pos)
    );

    cache_valid_array #(.POS_W(POS_W)) u_dvalid (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (cmd.d_all),
        .clr_one   (cmd.d_one),
        .clr_pos   (entry_pos),
        .fill_en   (d_fill_en),
        .fill_pos  (d_fill_pos),
        .look_pos  (d_look_pos),
        .look_valid(d_look_valid)
    );

    cache_valid_array #(.POS_W(POS_W)) u_ivalid (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (cmd.i_all),
        .clr_one   (cmd.i_one),
        .clr_pos   (entry_pos),
        .fill_en   (i_fill_en),
        .fill_pos  (i_fill_pos),
        .look_pos  (i_look_pos),
        .look_valid(i_look_valid)
    );

    assign d_enable      = fields.d_enable;
    assign d_freeze      = fields.d_freeze;
    assign d_burst       = fields.d_burst;
    assign d_write_alloc = fields.walloc & fields.d_enable & ~fields.d_freeze;
    assign i_enable      = fields.i_enable;
    assign i_freeze      = fields.i_freeze;
    assign i_burst       = fields.i_burst;
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr_en,
    input logic [31:0] ctl_wdata,
    input logic [31:0] ctl_rdata,
    input logic        d_enable,
    input logic        d_freeze,
    input logic        d_write_alloc,
    input logic        d_look_valid,
    input logic        i_look_valid
);
    // R2
    rdata_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[31:14] == '0) && (ctl_rdata[11:10] == 2'b00) &&
        (ctl_rdata[7:5] == 3'b000) && (ctl_rdata[3:2] == 2'b00));

    // R5
    walloc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_write_alloc |-> (d_enable && !d_freeze));

    // R1
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (ctl_rdata[13:12] == $past(ctl_wdata[13:12])) &&
                      (ctl_rdata[9:8] == $past(ctl_wdata[9:8])) &&
                      (ctl_rdata[4] == $past(ctl_wdata[4])) &&
                      (ctl_rdata[1:0] == $past(ctl_wdata[1:0])));

    // R6
    dclear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wdata[11]) |=> !d_look_valid);

    // R8
    iclear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wdata[3]) |=> !i_look_valid);
endmodule

bind cache_ctl_reg cache_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr_en    (ctl_wr_en),
    .ctl_wdata    (ctl_wdata),
    .ctl_rdata    (ctl_rdata),
    .d_enable     (d_enable),
    .d_freeze     (d_freeze),
    .d_write_alloc(d_write_alloc),
    .d_look_valid (d_look_valid),
    .i_look_valid (i_look_valid)
);

// File: tb/cache_ctl_reg_test.sv
module cache_ctl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr_en, caddr_wr_en;
    logic [31:0] ctl_wdata, caddr_wdata, ctl_rdata;
    logic        d_enable, d_freeze, d_burst, d_write_alloc;
    logic        i_enable, i_freeze, i_burst;
    logic        d_fill_en, i_fill_en;
    logic [5:0]  d_fill_pos, d_look_pos, i_fill_pos, i_look_pos;
    logic        d_look_valid, i_look_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cache_ctl_reg uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .caddr_wr_en(caddr_wr_en), .caddr_wdata(caddr_wdata),
        .d_enable(d_enable), .d_freeze(d_freeze), .d_burst(d_burst),
        .d_write_alloc(d_write_alloc),
        .i_enable(i_enable), .i_freeze(i_freeze), .i_burst(i_burst),
        .d_fill_en(d_fill_en), .d_fill_pos(d_fill_pos),
        .d_look_pos(d_look_pos), .d_look_valid(d_look_valid),
        .i_fill_en(i_fill_en), .i_fill_pos(i_fill_pos),
        .i_look_pos(i_look_pos), .i_look_valid(i_look_valid)
    );

    // write data, expected read data, expected {walloc,dbst,dfrz,den,ibst,ifrz,ien}
    typedef struct packed {
        logic [31:0] wd;
        logic [31:0] rd;
        logic [6:0]  pol;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'hFFFF_FFFF, 32'h0000_3313, 7'b0111111},
        '{32'h0000_2100, 32'h0000_2100, 7'b1001000},
        '{32'h0000_2000, 32'h0000_2000, 7'b0000000},
        '{32'h0000_1013, 32'h0000_1013, 7'b0100111},
        '{32'h0000_0C0C, 32'h0000_0000, 7'b0000000},
        '{32'hFFFF_C0E0, 32'h0000_0000, 7'b0000000}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(logic [31:0] v);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr_en = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wr_addr(logic [3:0] idx, logic [1:0] sel);
        @(negedge clk); caddr_wr_en = 1'b1; caddr_wdata = {24'h0, idx, sel, 2'b00};
        @(negedge clk); caddr_wr_en = 1'b0;
    endtask

    task automatic dfill(logic [5:0] p);
        @(negedge clk); d_fill_en = 1'b1; d_fill_pos = p;
        @(negedge clk); d_fill_en = 1'b0;
    endtask

    task automatic ifill(logic [5:0] p);
        @(negedge clk); i_fill_en = 1'b1; i_fill_pos = p;
        @(negedge clk); i_fill_en = 1'b0;
    endtask

    function automatic logic dlook(logic [5:0] p);
        return 1'b0;
    endfunction

    task automatic chk_d(string tag, logic [5:0] p, logic exp);
        d_look_pos = p; #1;
        check(tag, {31'h0, d_look_valid}, {31'h0, exp});
    endtask

    task automatic chk_i(string tag, logic [5:0] p, logic exp);
        i_look_pos = p; #1;
        check(tag, {31'h0, i_look_valid}, {31'h0, exp});
    endtask

    function automatic logic [6:0] pol_now();
        return {d_write_alloc, d_burst, d_freeze, d_enable, i_burst, i_freeze, i_enable};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctl_wr_en = 0; ctl_wdata = 0; caddr_wr_en = 0; caddr_wdata = 0;
        d_fill_en = 0; d_fill_pos = 0; d_look_pos = 0;
        i_fill_en = 0; i_fill_pos = 0; i_look_pos = 0;
        repeat (3) @(negedge clk);
        // R3 reset state
        check("R3 rdata", ctl_rdata, 32'h0);
        check("R3 policy", {25'h0, pol_now()}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_d("R3 dvalid", 6'd5, 1'b0);
        chk_i("R3 ivalid", 6'd5, 1'b0);

        // R1 R2 R4 R5 vector table
        foreach (VECS[k]) begin
            wr_ctl(VECS[k].wd);
            check($sformatf("R1/R2 rdata vec%0d", k), ctl_rdata, VECS[k].rd);
            check($sformatf("R4/R5 policy vec%0d", k), {25'h0, pol_now()}, {25'h0, VECS[k].pol});
        end

        // R9 fill visible next cycle
        dfill(6'd9); dfill(6'd10); dfill(6'd11); dfill(6'd40);
        chk_d("R9 fill 9", 6'd9, 1'b1);
        chk_d("R9 fill 40", 6'd40, 1'b1);
        chk_d("R9 unfilled 12", 6'd12, 1'b0);

        // R7 entry clear: index 2, select 2 -> pos 10; cache disabled and frozen
        wr_addr(4'd2, 2'd2);
        wr_ctl(32'h0000_0600);
        chk_d("R7 target 10 cleared", 6'd10, 1'b0);
        chk_d("R7 neighbour 9 kept", 6'd9, 1'b1);
        chk_d("R7 neighbour 11 kept", 6'd11, 1'b1);
        chk_d("R7 other line 40 kept", 6'd40, 1'b1);

        // R9 fill and entry clear same cycle on pos 10: clear wins
        @(negedge clk);
        d_fill_en = 1'b1; d_fill_pos = 6'd10; ctl_wr_en = 1'b1; ctl_wdata = 32'h0000_0400;
        @(negedge clk);
        d_fill_en = 1'b0; ctl_wr_en = 1'b0; ctl_wdata = 0;
        chk_d("R9 clear wins over fill", 6'd10, 1'b0);

        // R6 clear all data, with a fill colliding
        @(negedge clk);
        d_fill_en = 1'b1; d_fill_pos = 6'd63; ctl_wr_en = 1'b1; ctl_wdata = 32'h0000_0800;
        @(negedge clk);
        d_fill_en = 1'b0; ctl_wr_en = 1'b0; ctl_wdata = 0;
        chk_d("R6 pos 9 cleared", 6'd9, 1'b0);
        chk_d("R6 pos 40 cleared", 6'd40, 1'b0);
        chk_d("R6 colliding fill 63 cleared", 6'd63, 1'b0);
        check("R6 rdata reads zero", ctl_rdata, 32'h0);

        // R8 instruction side
        ifill(6'd20); ifill(6'd21); ifill(6'd50); dfill(6'd21);
        wr_addr(4'd5, 2'd1);   // pos 21
        wr_ctl(32'h0000_0004);
        chk_i("R8 entry 21 cleared", 6'd21, 1'b0);
        chk_i("R8 entry 20 kept", 6'd20, 1'b1);
        chk_d("R8 data side untouched", 6'd21, 1'b1);
        wr_ctl(32'h0000_0008);
        chk_i("R8 clear all 50", 6'd50, 1'b0);
        chk_i("R8 clear all 20", 6'd20, 1'b0);
        chk_d("R8 data kept after iclear", 6'd21, 1'b1);

        // R3 reset mid-run clears valid bits and control
        wr_ctl(32'h0000_3313);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R3 rdata after reset", ctl_rdata, 32'h0);
        chk_d("R3 dvalid after reset", 6'd21, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule